// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block counts enable pulses from a 1 kHz tick and raises an interrupt once a programmed delay has passed. A 4-bit control word picks the delay and the behaviour after a timeout. The low three bits choose one of seven fixed delays, from a tenth of a second up to one minute. The top bit chooses between a single-shot timeout and a repeating one. A separate start/stop write holds the timer idle and clears it, or lets it run. A status read clears a pending interrupt. The tick source and the bus decode lie outside the block.

The control flow is a three-state machine. `PIT_HALT` means the timer is stopped and its count is held at zero. `PIT_RUN` means it is counting ticks. `PIT_DONE` means a single-shot delay has expired and the timer waits to be restarted. The transitions are:
- HALT to RUN on a start write while a nonzero delay code is held.
- RUN to DONE on a timeout in single mode.
- RUN to RUN on a timeout in repeat mode, with the count wrapping.
- DONE to RUN on a start write.
- Any state to HALT on a stop write or on a control write with delay code zero.

In repeat mode the count wraps at the end of each period and never restarts when the interrupt is serviced. Every later timeout therefore keeps the phase of the first one, and error does not build up.

Top module: `pit_timer`

## Requirements
- R1: While reset is asserted and right after it, `irq` and `running` are 0 and the held control word is zero, so the timer is in `PIT_HALT`.
- R2: Delay codes 1..7 in bits 2..0 select 1, 5, 10, 50, 100, 300 and 600 times `TICKS_PER_100MS` ticks. With ticks present every cycle, `irq` first rises exactly that many clock edges after the edge that takes a start write.
- R3: A control write with bits 2..0 = 000 clears `irq` and forces `PIT_HALT`. A start write made while that code is held leaves the timer stopped and no interrupt follows. If a control write and a start write arrive in the same cycle, the control write wins.
- R4: A stop write (`run_we`=1, `run_stop`=1) moves to `PIT_HALT` and clears the count. No interrupt follows, and a later start write times a full period from zero.
- R5: After reset, or after a stop, the timer does not count until a start write (`run_we`=1, `run_stop`=0) is taken. Every start write restarts the count from zero.
- R6: With bit 3 = 0 (single mode), a timeout sets `irq` and moves to `PIT_DONE`, where `running` is 0. A new start write is needed to time again.
- R7: With bit 3 = 1 (repeat mode), the timer stays in `PIT_RUN` after a timeout and the next timeout follows exactly one period later. Clearing `irq` in between does not shift this.
- R8: `irq` stays 1 until a status read (`status_rd`=1) or a control write. If a timeout falls in the same cycle as a status read, `irq` stays 1.
- R9: The count advances only on cycles where `tick_en` is 1. Cycles without a tick do not advance it.
- R10: A nonzero control write restarts the count from zero and leaves the run state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 1 kHz tick enable, one cycle wide |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: bits 2..0 delay code, bit 3 repeat mode |
| run_we | input | 1 | Start/stop write strobe |
| run_stop | input | 1 | Start/stop value: 1 stops and clears, 0 starts |
| status_rd | input | 1 | Status read strobe, clears the interrupt |
| irq | output | 1 | Interrupt output |
| running | output | 1 | 1 while the timer is in `PIT_RUN` |

## Verification
The bench drives every strobe just after a falling edge, so each strobe is taken by exactly one rising edge. It samples on the next falling edge, when one rising edge has passed since the stimulus.

Control writes, start/stop writes and status reads take effect on `running` and `irq` at the first rising edge that samples the strobe. The bench checks them on the falling edge that follows.

A timeout of P ticks raises `irq` exactly P tick-bearing edges after the start edge. The bench checks `irq` low at edge P-1 and high at edge P. In repeat mode it checks again at edge 2P, counting from the same start edge and not from the status read.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [1:0] {
        PIT_HALT = 2'd0,
        PIT_RUN  = 2'd1,
        PIT_DONE = 2'd2
    } pit_state_e;

    localparam int PIT_CODE_W   = 3;
    localparam int PIT_CODES    = 1 << PIT_CODE_W;
    localparam int PIT_MAX_MULT = 600;

    // Delay in units of 100 ms for each code; code 0 disables the timer.
    function automatic int unsigned period_mult(input int unsigned code);
        case (code)
            1:       period_mult = 1;
            2:       period_mult = 5;
            3:       period_mult = 10;
            4:       period_mult = 50;
            5:       period_mult = 100;
            6:       period_mult = 300;
            7:       period_mult = PIT_MAX_MULT;
            default: period_mult = 0;
        endcase
    endfunction

endpackage

// File: rtl/pit_period_lut.sv
module pit_period_lut #(
    parameter int TICKS_PER_100MS = 100,
    parameter int CNT_W           = 16
) (
    input  logic [pit_pkg::PIT_CODE_W-1:0] code,
    output logic [CNT_W-1:0]               period
);
    import pit_pkg::*;

    logic [CNT_W-1:0] table_q [PIT_CODES];

    for (genvar g = 0; g < PIT_CODES; g++) begin : g_entry
        assign table_q[g] = CNT_W'(period_mult(g) * TICKS_PER_100MS);
    end

    assign period = table_q[code];

endmodule

// File: rtl/pit_tick_counter.sv
module pit_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             hit
);
    logic [CNT_W-1:0] count_q;
    logic             at_end;

    assign at_end = (period != '0) && (count_q == period - 1'b1);
    assign hit    = en && tick && at_end;

    // Wrap at the period end so repeated timeouts keep the first phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr) begin
            count_q <= '0;
        end else if (en && tick) begin
            count_q <= at_end ? '0 : count_q + 1'b1;
        end
    end

endmodule

// File: rtl/pit_ctrl_fsm.sv
module pit_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic new_code_zero,
    input  logic run_we,
    input  logic run_stop,
    input  logic held_code_zero,
    input  logic mode_rep,
    input  logic hit,
    output logic run_en,
    output logic cnt_clr
);
    import pit_pkg::*;

    pit_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIT_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            if (new_code_zero) state_d = PIT_HALT;
        end else if (run_we) begin
            if (run_stop || held_code_zero) state_d = PIT_HALT;
            else                            state_d = PIT_RUN;
        end else begin
            unique case (state_q)
                PIT_HALT: state_d = PIT_HALT;
                PIT_RUN:  state_d = (hit && !mode_rep) ? PIT_DONE : PIT_RUN;
                PIT_DONE: state_d = PIT_DONE;
                default:  state_d = PIT_HALT;
            endcase
        end
    end

    always_comb begin
        run_en  = 1'b0;
        cnt_clr = cfg_we || run_we;
        unique case (state_q)
            PIT_RUN:  run_en  = 1'b1;
            PIT_HALT: cnt_clr = 1'b1;
            PIT_DONE: cnt_clr = 1'b1;
            default:  cnt_clr = 1'b1;
        endcase
    end

endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
    parameter int TICKS_PER_100MS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       cfg_we,
    input  logic [3:0] cfg_wdata,
    input  logic       run_we,
    input  logic       run_stop,
    input  logic       status_rd,
    output logic       irq,
    output logic       running
);
    import pit_pkg::*;

    localparam int CNT_W = $clog2(PIT_MAX_MULT * TICKS_PER_100MS + 1);

    logic [3:0]       cfg_q;
    logic [CNT_W-1:0] period;
    logic             run_en;
    logic             cnt_clr;
    logic             cnt_hit;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wdata;
    end

    pit_period_lut #(
        .TICKS_PER_100MS(TICKS_PER_100MS),
        .CNT_W          (CNT_W)
    ) u_lut (
        .code  (cfg_q[PIT_CODE_W-1:0]),
        .period(period)
    );

    pit_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .new_code_zero (cfg_wdata[PIT_CODE_W-1:0] == '0),
        .run_we        (run_we),
        .run_stop      (run_stop),
        .held_code_zero(cfg_q[PIT_CODE_W-1:0] == '0),
        .mode_rep      (cfg_q[3]),
        .hit           (cnt_hit),
        .run_en        (run_en),
        .cnt_clr       (cnt_clr)
    );

    pit_tick_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (run_en && !cfg_we && !run_we),
        .tick  (tick_en),
        .period(period),
        .hit   (cnt_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (cfg_we)    irq_q <= 1'b0;
        else if (cnt_hit)   irq_q <= 1'b1;
        else if (status_rd) irq_q <= 1'b0;
    end

    assign irq     = irq_q;
    assign running = run_en;

endmodule

// File: rtl/pit_timer_checker.sv
module pit_timer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [3:0] cfg_wdata,
    input logic       run_we,
    input logic       run_stop,
    input logic       status_rd,
    input logic       irq,
    input logic       running,
    input logic       hit,
    input logic       mode_rep
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (!irq && !running));

    assert_zero_code_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[2:0] == 3'b000) |=> (!irq && !running));

    assert_stop_halts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_we && run_stop && !cfg_we) |=> !running);

    assert_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(run_we && !run_stop)) |=> !running);

    assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !mode_rep) |=> (irq && !running));

    assert_repeat_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode_rep) |=> (irq && running));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !status_rd && !cfg_we) |=> irq);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !cfg_we && !hit) |=> !irq);

    assert_hit_only_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> running);

endmodule

bind pit_timer pit_timer_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .run_we   (run_we),
    .run_stop (run_stop),
    .status_rd(status_rd),
    .irq      (irq),
    .running  (running),
    .hit      (cnt_hit),
    .mode_rep (cfg_q[3])
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 2;
    localparam int NVEC       = 7;
    // {code, multiple of 100 ms}
    localparam int VEC [NVEC][2] = '{
        '{1, 1}, '{2, 5}, '{3, 10}, '{4, 50}, '{5, 100}, '{6, 300}, '{7, 600}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_wdata = '0;
    logic       run_we = 1'b0;
    logic       run_stop = 1'b0;
    logic       status_rd = 1'b0;
    logic       irq;
    logic       running;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pit_timer #(.TICKS_PER_100MS(BASE)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .run_we   (run_we),
        .run_stop (run_stop),
        .status_rd(status_rd),
        .irq      (irq),
        .running  (running)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_run(input logic stop);
        run_we = 1'b1; run_stop = stop;
        @(negedge clk);
        run_we = 1'b0;
    endtask

    task automatic rd_status();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        chk(irq, 1'b0, "R1 irq in reset");
        chk(running, 1'b0, "R1 running in reset");
        rst_n = 1'b1;
        wait_cyc(1);
        chk(irq, 1'b0, "R1 irq after reset");
        // R5: no counting without a start write
        wr_cfg(4'b0001);
        wait_cyc(10);
        chk(running, 1'b0, "R5 idle until start");
        chk(irq, 1'b0, "R5 no irq before start");

        // R2 / R6: vector table, single mode
        for (int v = 0; v < NVEC; v++) begin
            int p;
            p = VEC[v][1] * BASE;
            wr_cfg({1'b0, 3'(VEC[v][0])});
            wr_run(1'b0);
            chk(running, 1'b1, "R5 start runs");
            wait_cyc(p - 1);
            chk(irq, 1'b0, "R2 irq before period");
            wait_cyc(1);
            chk(irq, 1'b1, "R2 irq at period");
            chk(running, 1'b0, "R6 single stops");
            wait_cyc(p + 2);
            chk(irq, 1'b1, "R8 irq held");
            chk(running, 1'b0, "R6 stays done");
        end

        // R7 / R8: repeat mode, period 10, service in between
        wr_cfg(4'b1010);
        chk(irq, 1'b0, "R8 cfg write clears irq");
        wr_run(1'b0);
        wait_cyc(9);
        chk(irq, 1'b0, "R7 before first");
        wait_cyc(1);
        chk(irq, 1'b1, "R7 first timeout");
        chk(running, 1'b1, "R7 keeps running");
        wait_cyc(2);
        chk(irq, 1'b1, "R8 sticky");
        rd_status();
        chk(irq, 1'b0, "R8 read clears");
        wait_cyc(6);
        chk(irq, 1'b0, "R7 before second");
        wait_cyc(1);
        chk(irq, 1'b1, "R7 second timeout in phase");

        // R8: read coinciding with timeout keeps irq (period 2, repeat)
        wr_cfg(4'b1001);
        wr_run(1'b0);
        wait_cyc(1);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk(irq, 1'b1, "R8 timeout wins over read");

        // R3: zero code halts and ignores start
        wr_cfg(4'b1000);
        chk(irq, 1'b0, "R3 irq cleared");
        chk(running, 1'b0, "R3 halted");
        wr_run(1'b0);
        chk(running, 1'b0, "R3 start ignored");
        wait_cyc(30);
        chk(irq, 1'b0, "R3 no interrupt");
        // R3: same-cycle control write wins over start
        wr_cfg(4'b0011);
        wr_run(1'b0);
        cfg_we = 1'b1; cfg_wdata = 4'b0000; run_we = 1'b1; run_stop = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; run_we = 1'b0;
        chk(running, 1'b0, "R3 control write wins");

        // R4: stop mid-count, later full period from zero (period 20)
        wr_cfg(4'b0011);
        wr_run(1'b0);
        wait_cyc(8);
        wr_run(1'b1);
        chk(running, 1'b0, "R4 stop halts");
        wait_cyc(30);
        chk(irq, 1'b0, "R4 no irq after stop");
        wr_run(1'b0);
        wait_cyc(19);
        chk(irq, 1'b0, "R4 full period from zero");
        wait_cyc(1);
        chk(irq, 1'b1, "R4 timeout after restart");

        // R10: nonzero control write mid-count restarts the count
        wr_cfg(4'b0011);
        wr_run(1'b0);
        wait_cyc(9);
        wr_cfg(4'b0011);
        chk(running, 1'b1, "R10 run state kept");
        wait_cyc(19);
        chk(irq, 1'b0, "R10 count restarted");
        wait_cyc(1);
        chk(irq, 1'b1, "R10 timeout from write");

        // R9: no tick, no progress (period 2)
        wr_cfg(4'b0001);
        tick_en = 1'b0;
        wr_run(1'b0);
        wait_cyc(5);
        chk(irq, 1'b0, "R9 held without ticks");
        tick_en = 1'b1;
        wait_cyc(1);
        chk(irq, 1'b0, "R9 one tick");
        wait_cyc(1);
        chk(irq, 1'b1, "R9 second tick times out");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule